// File: doc/BRIEF.md
# Single-Precision Reciprocal Seed Unit

This unit takes one IEEE-754 single-precision value and returns a coarse approximation of its reciprocal, good to roughly eight bits. The result is meant as a starting point for a later refinement step. It does not use a divider. The fraction's leading eight bits select one of 256 precomputed seeds. The result exponent is formed by subtracting the operand's biased exponent from a fixed constant. The operand's sign is carried to the result unchanged.

Special operands take their own paths, and each keeps its sign:
- NaN passes through untouched.
- Infinities, and values so large that the reciprocal would fall below the normal range, become zeros.
- Zeros and denormals become infinities.

The seed table is filled at elaboration by a constant integer function, so the unit holds no stored contents. There is one register stage. A request is a word plus a valid flag, and the answer appears with its own valid flag one clock later. The reset is asynchronous and active-low. It is expected to be released synchronously to the clock by the surrounding logic.

Top module: `recip_est_unit`

## Requirements
- R1: `res_valid` is high in exactly those cycles that follow a cycle in which `op_valid` was high (one cycle of latency, no gaps, no extra pulses).
- R2: In a cycle where `op_valid` is low, `res_word` keeps the value it had in the previous cycle, whatever `op_word` carries.
- R3: While `rst_n` is low, `res_valid` is 0 and `res_word` is 0x00000000.
- R4: An operand with exponent field (bits 30:23) equal to 255 and a nonzero fraction (bits 22:0) is returned bit for bit unchanged.
- R5: An infinity (exponent 255, fraction 0), or an operand with exponent field 253 or 254, returns a zero with the operand's sign bit (bit 31): 0x00000000 or 0x80000000.
- R6: An operand with exponent field 0 (a zero or a denormal) returns an infinity with the operand's sign: 0x7F800000 or 0xFF800000.
- R7: For an operand with exponent field e in 1..252, the result's exponent field is 253 − e and its sign bit equals the operand's.
- R8: For such an operand, let q = 256 + fraction bits 22:15 and s = round(2^17 / (q + 0.5)). The result fraction bits 22:15 hold s − 256, and bits 14:0 are zero.
- R9: The seed is 255 (s = 511) for fraction bits 22:15 equal to 0x00, and 0 (s = 256) for 0xFF. So the estimate spans 1.0 to 511/256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operand word is valid this cycle |
| op_word | input | 32 | Single-precision operand |
| res_valid | output | 1 | Result word is valid |
| res_word | output | 32 | Single-precision reciprocal estimate |

## Verification
Every result of this unit, normal or special, is due in the first cycle after the operand was accepted; nothing depends on the operand class. The driver applies an operand on a falling edge and pushes the expected word into a queue. The monitor samples shortly after each rising edge and pops the oldest entry whenever `res_valid` is high, so each result is compared in exactly the cycle following its request. Idle gaps between requests are used to confirm that the valid flag drops and that the output word is held.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

  typedef enum logic [1:0] {
    OPC_NAN  = 2'd0,
    OPC_BIG  = 2'd1,
    OPC_TINY = 2'd2,
    OPC_NORM = 2'd3
  } op_class_e;

  // Seed for bucket q in [2^w, 2^(w+1)): round(2^(2w+2)/(2q+1)) - 2^w
  function automatic int seed_calc(input int q, input int w);
    longint num;
    longint den;
    longint val;
    num = longint'(1) << (2 * w + 2);
    den = 2 * longint'(q) + 1;
    val = (2 * num + den) / (2 * den);
    return int'(val - (longint'(1) << w));
  endfunction

endpackage

// File: rtl/recip_operand_class.sv
module recip_operand_class #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W-1:0]          exp_f,
  input  logic [FRAC_W-1:0]         frac_f,
  output recip_est_pkg::op_class_e  op_class
);
  import recip_est_pkg::*;

  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int BIG_MIN = 2 * BIAS - 1;

  logic exp_max;
  logic exp_zero;
  logic frac_nz;
  logic exp_big;

  always_comb begin
    exp_max  = &exp_f;
    exp_zero = ~|exp_f;
    frac_nz  = |frac_f;
    exp_big  = exp_f >= EXP_W'(BIG_MIN);
    if (exp_max && frac_nz) begin
      op_class = OPC_NAN;
    end else if (exp_big) begin
      op_class = OPC_BIG;
    end else if (exp_zero) begin
      op_class = OPC_TINY;
    end else begin
      op_class = OPC_NORM;
    end
  end

endmodule

// File: rtl/recip_seed_rom.sv
module recip_seed_rom #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] seed
);
  import recip_est_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign rom[i] = IDX_W'(seed_calc(DEPTH + i, IDX_W));
  end

  assign seed = rom[idx];

endmodule

// File: rtl/recip_result_mux.sv
module recip_result_mux #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int IDX_W  = 8
) (
  input  recip_est_pkg::op_class_e  op_class,
  input  logic                      sign_f,
  input  logic [EXP_W-1:0]          exp_f,
  input  logic [FRAC_W-1:0]         frac_f,
  input  logic [IDX_W-1:0]          seed,
  output logic [EXP_W+FRAC_W:0]     result
);
  import recip_est_pkg::*;

  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int RES_BASE = 2 * BIAS - 1;
  localparam int PAD_W    = FRAC_W - IDX_W;

  logic [EXP_W-1:0] res_exp;

  always_comb begin
    res_exp = EXP_W'(RES_BASE) - exp_f;
    unique case (op_class)
      OPC_NAN:  result = {sign_f, exp_f, frac_f};
      OPC_BIG:  result = {sign_f, {(EXP_W + FRAC_W){1'b0}}};
      OPC_TINY: result = {sign_f, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      default:  result = {sign_f, res_exp, seed, {PAD_W{1'b0}}};
    endcase
  end

endmodule

// File: rtl/recip_est_unit.sv
module recip_est_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int IDX_W  = 8,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] op_word,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word
);
  import recip_est_pkg::*;

  logic              sign_f;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  seed;
  op_class_e         op_class;
  logic [WORD_W-1:0] assembled;

  logic              valid_d;
  logic              valid_q;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;

  assign sign_f = op_word[WORD_W-1];
  assign exp_f  = op_word[FRAC_W +: EXP_W];
  assign frac_f = op_word[FRAC_W-1:0];
  assign idx    = frac_f[FRAC_W-1 -: IDX_W];

  recip_operand_class #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
  ) u_class (
    .exp_f    (exp_f),
    .frac_f   (frac_f),
    .op_class (op_class)
  );

  recip_seed_rom #(
    .IDX_W (IDX_W)
  ) u_rom (
    .idx  (idx),
    .seed (seed)
  );

  recip_result_mux #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .IDX_W  (IDX_W)
  ) u_mux (
    .op_class (op_class),
    .sign_f   (sign_f),
    .exp_f    (exp_f),
    .frac_f   (frac_f),
    .seed     (seed),
    .result   (assembled)
  );

  always_comb begin
    valid_d = op_valid;
    word_d  = word_q;
    if (op_valid) begin
      word_d = assembled;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign res_valid = valid_q;
  assign res_word  = word_q;

endmodule

// File: rtl/recip_est_checker.sv
module recip_est_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [WORD_W-1:0] op_word,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_word
);

  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int RES_BASE = 2 * BIAS - 1;
  localparam int PAD_W    = FRAC_W - 8;

  logic [EXP_W-1:0] in_exp;
  logic             in_nan;
  logic             in_big;
  logic             in_tiny;
  logic             in_norm;

  assign in_exp  = op_word[FRAC_W +: EXP_W];
  assign in_nan  = (&in_exp) && (|op_word[FRAC_W-1:0]);
  assign in_big  = !in_nan && (in_exp >= EXP_W'(RES_BASE));
  assign in_tiny = (in_exp == '0);
  assign in_norm = !in_nan && !in_big && !in_tiny;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r3_reset_clear: assert (!res_valid && res_word == '0);
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);

  a_r2_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_word));

  a_r4_nan_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_nan) |=> res_word == $past(op_word));

  a_r5_signed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_big) |=>
      (res_word[WORD_W-2:0] == '0) && (res_word[WORD_W-1] == $past(op_word[WORD_W-1])));

  a_r6_signed_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_tiny) |=>
      res_word == {$past(op_word[WORD_W-1]), {EXP_W{1'b1}}, {FRAC_W{1'b0}}});

  a_r7_exponent: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_norm) |=>
      (res_word[FRAC_W +: EXP_W] == EXP_W'(RES_BASE) - $past(in_exp)) &&
      (res_word[WORD_W-1] == $past(op_word[WORD_W-1])));

  a_r8_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_norm) |=> res_word[PAD_W-1:0] == '0);

endmodule

bind recip_est_unit recip_est_checker #(
  .EXP_W  (EXP_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_word   (op_word),
  .res_valid (res_valid),
  .res_word  (res_word)
);

// File: tb/test_recip_est_unit.sv
module test_recip_est_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        op_valid;
  logic [31:0] op_word;
  logic        res_valid;
  logic [31:0] res_word;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  recip_est_unit i_recip_est_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_word   (op_word),
    .res_valid (res_valid),
    .res_word  (res_word)
  );

  function automatic logic [31:0] model(input logic [31:0] w);
    int  e;
    int  q;
    int  s;
    real r;
    e = int'(w[30:23]);
    if (e == 255 && w[22:0] != 0) return w;
    if (e >= 253) return {w[31], 31'd0};
    if (e == 0) return {w[31], 8'hFF, 23'd0};
    q = 256 + int'(w[22:15]);
    r = 131072.0 / (real'(q) + 0.5);
    s = $rtoi(r + 0.5);
    return {w[31], 8'(253 - e), 8'(s - 256), 15'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] w, input string req);
    @(negedge clk);
    op_valid = 1'b1;
    op_word  = w;
    exp_q.push_back(model(w));
    tag_q.push_back(req);
  endtask

  task automatic idle(input logic [31:0] junk);
    @(negedge clk);
    op_valid = 1'b0;
    op_word  = junk;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && res_valid) begin
        if (exp_q.size() == 0) begin
          check("R1 unexpected valid", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(), res_word, exp_q.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  logic [31:0] held;

  initial begin
    op_valid = 1'b0;
    op_word  = 32'h0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R3 reset valid", {31'd0, res_valid}, 32'd0);
    check("R3 reset word", res_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    send(32'h3F800000, "R7 one");
    send(32'hBF800000, "R7 minus one");
    send(32'h40000000, "R7 two");
    send(32'h3FC00000, "R8 one point five");
    send(32'h43130000, "R8 147");
    send(32'h7E000000, "R7 exp 252 boundary");
    send(32'h00800000, "R7 smallest normal");
    send(32'h7E800000, "R5 exp 253 positive");
    send(32'hFE800000, "R5 exp 253 negative");
    send(32'h7F000000, "R5 exp 254");
    send(32'h7F800000, "R5 plus inf");
    send(32'hFF800000, "R5 minus inf");
    send(32'h00000000, "R6 plus zero");
    send(32'h80000000, "R6 minus zero");
    send(32'h00000001, "R6 denormal positive");
    send(32'h807FFFFF, "R6 denormal negative");
    send(32'h7FC00000, "R4 quiet nan");
    send(32'hFF800001, "R4 signaling nan");
    idle(32'h0);
    idle(32'h0);
    check("R1 queue drained", exp_q.size(), 32'd0);

    // R9 extremes of the seed range
    send(32'h3F800000, "R9 index 0x00 seed 255");
    @(negedge clk);
    check("R9 seed at 0x00", {24'd0, res_word[22:15]}, 32'd255);
    op_valid = 1'b1;
    op_word  = 32'h3FFF8000;
    exp_q.push_back(model(32'h3FFF8000));
    tag_q.push_back("R9 index 0xFF seed 0");
    @(negedge clk);
    op_valid = 1'b0;
    check("R9 seed at 0xFF", {24'd0, res_word[22:15]}, 32'd0);

    // R2 hold with junk input while idle
    held = res_word;
    idle(32'h00000000);
    idle(32'h7F800000);
    check("R2 held word", res_word, held);
    check("R1 valid low when idle", {31'd0, res_valid}, 32'd0);
    idle(32'h3F800000);
    check("R2 held word late", res_word, held);

    // R8 sweep over every table index, alternating sign and exponent
    for (int i = 0; i < 256; i++) begin
      send({i[0], 8'(100 + (i % 50)), 8'(i), 15'(i * 97)}, "R8 sweep");
    end
    idle(32'h0);
    idle(32'h0);
    check("R1 sweep drained", exp_q.size(), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule